// File: doc/BRIEF.md
# Subtract-Based Compare Flag Unit

This block compares two WIDTH-bit operands by forming their difference through a two's-complement subtraction (operand A plus the inverted operand B plus one). It keeps only the status flags of that subtraction and then drops the difference itself. The flags are zero, negative, carry and overflow.

From the flags the block derives three ordering predicates: equality, unsigned less-than and signed less-than. The signed predicate is the negative flag XOR the overflow flag, so a subtraction that overflows and flips the sign bit still gives the right order. The unit is purely combinational. Branch or select logic elsewhere reads its predicates within the same cycle in which the operands are presented.

Top module: `cmp_flag_unit`

## Requirements
- R1: flagZero is 1 exactly when opA equals opB, that is, when every bit of the internal difference is 0.
- R2: flagNeg equals bit WIDTH-1 of the difference (opA - opB) taken modulo 2^WIDTH.
- R3: flagCarry is the carry out of opA + ~opB + 1. It is 1 exactly when opA >= opB as unsigned numbers, so a 0 means a borrow occurred.
- R4: flagOvf is 1 exactly when the sign bits of opA and opB differ and the sign bit of the difference differs from the sign bit of opA. Equivalently, it is 1 when the true signed difference lies outside the range of WIDTH-bit two's complement.
- R5: isEqual is 1 exactly when opA equals opB, and it always matches flagZero.
- R6: isLessU is 1 exactly when opA < opB as unsigned numbers, and it always equals the inverse of flagCarry.
- R7: isLessS is 1 exactly when opA < opB as two's-complement numbers, and it always equals flagNeg XOR flagOvf.
- R8: With WIDTH = 8, opA = 0xFF and opB = 0x01 give isLessU = 0 and isLessS = 1: unsigned A is greater, and signed A is smaller.
- R9: The unit holds no state. Every output reflects the current operands without waiting for a clock edge, and the difference is never driven onto a port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | Minuend operand |
| opB | input | WIDTH | Subtrahend operand |
| flagZero | output | 1 | Difference is all zeros |
| flagNeg | output | 1 | Most significant bit of the difference |
| flagCarry | output | 1 | Carry out of the subtraction (1 = no borrow) |
| flagOvf | output | 1 | Signed overflow of the subtraction |
| isEqual | output | 1 | opA equals opB |
| isLessU | output | 1 | opA below opB, unsigned |
| isLessS | output | 1 | opA below opB, signed |

## Verification
The signed and unsigned orderings come out of the same subtraction at the same moment. Whenever the two operand sign bits differ, they must disagree, and overflow then decides whether the negative flag is inverted. This pairing is provoked by an exhaustive sweep of all 65536 operand pairs at the default width, together with directed extremes such as 0xFF against 0x01 and 0x80 against 0x7F. Each predicate is judged against plain relational comparison under both the unsigned and the signed reading, and each flag against arithmetic done on wider integers.

// File: rtl/cmp_flag_pkg.sv
package cmp_flag_pkg;

  // Strobes the control side hands to the subtractor datapath.
  typedef struct packed {
    logic invertB;   // feed the bitwise complement of operand B
    logic carryIn;   // inject a one at the bottom of the carry chain
  } subStrobe_t;

  // Raw status produced by the datapath.
  typedef struct packed {
    logic zero;
    logic negative;
    logic carry;
    logic overflow;
  } subFlags_t;

endpackage

// File: rtl/cmp_datapath.sv
module cmp_datapath
  import cmp_flag_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  subStrobe_t       strobe,
  output subFlags_t        flags
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] bEff;
  logic [WIDTH-1:0] diff;
  logic [WIDTH:0]   carryChain;

  // Operand conditioning, one bit at a time.
  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_cond
      assign bEff[gi] = opB[gi] ^ strobe.invertB;
    end
  endgenerate

  // Ripple carry chain; the difference stays inside this module.
  always_comb begin
    carryChain[0] = strobe.carryIn;
    for (int i = 0; i < WIDTH; i++) begin
      diff[i]           = opA[i] ^ bEff[i] ^ carryChain[i];
      carryChain[i + 1] = (opA[i] & bEff[i]) | (carryChain[i] & (opA[i] ^ bEff[i]));
    end
  end

  always_comb begin
    flags.zero     = ~|diff;
    flags.negative = diff[MSB];
    flags.carry    = carryChain[WIDTH];
    // Signed overflow: carry into the sign bit differs from carry out of it.
    flags.overflow = carryChain[WIDTH] ^ carryChain[MSB];
  end

  // Checks next to the logic they guard (subtract mode only).
  always_comb begin
    if (strobe.invertB && strobe.carryIn) begin
      assert_zero_means_equal_R1 : assert (flags.zero == (opA == opB));
      assert_carry_no_borrow_R3 : assert (flags.carry == (opA >= opB));
      assert_ovf_sign_rule_R4 : assert (flags.overflow ==
        ((opA[MSB] != opB[MSB]) && (flags.negative != opA[MSB])));
    end
  end

endmodule

// File: rtl/cmp_control.sv
module cmp_control
  import cmp_flag_pkg::*;
(
  input  subFlags_t  flags,
  output subStrobe_t strobe,
  output logic       isEqual,
  output logic       isLessU,
  output logic       isLessS
);

  // Compare is always a subtraction: A + ~B + 1.
  always_comb begin
    strobe.invertB = 1'b1;
    strobe.carryIn = 1'b1;
  end

  // Predicates read off the subtractor status.
  always_comb begin
    isEqual = flags.zero;
    isLessU = ~flags.carry;
    isLessS = flags.negative ^ flags.overflow;
  end

  always_comb begin
    // An equal pair cannot also be strictly ordered.
    assert_equal_excludes_less_R5 : assert (!(isEqual && (isLessU || isLessS)));
    // A zero difference never carries a negative sign or an overflow.
    assert_zero_clean_R7 : assert (!(flags.zero && (flags.negative || flags.overflow)));
  end

endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit
  import cmp_flag_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             flagZero,
  output logic             flagNeg,
  output logic             flagCarry,
  output logic             flagOvf,
  output logic             isEqual,
  output logic             isLessU,
  output logic             isLessS
);

  subStrobe_t strobe;
  subFlags_t  flags;

  cmp_datapath #(.WIDTH(WIDTH)) u_datapath (
    .opA   (opA),
    .opB   (opB),
    .strobe(strobe),
    .flags (flags)
  );

  cmp_control u_control (
    .flags  (flags),
    .strobe (strobe),
    .isEqual(isEqual),
    .isLessU(isLessU),
    .isLessS(isLessS)
  );

  assign flagZero  = flags.zero;
  assign flagNeg   = flags.negative;
  assign flagCarry = flags.carry;
  assign flagOvf   = flags.overflow;

  // Ordering predicates against direct relational comparison.
  always_comb begin
    assert_unsigned_order_R6 : assert (isLessU == (opA < opB));
    assert_signed_order_R7 : assert (isLessS == ($signed(opA) < $signed(opB)));
  end

endmodule

// File: tb/test_cmp_flag_unit.sv
module test_cmp_flag_unit;

  localparam int W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic flagZero, flagNeg, flagCarry, flagOvf, isEqual, isLessU, isLessS;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  cmp_flag_unit #(.WIDTH(W)) i_cmp_flag_unit (
    .opA(opA), .opB(opB),
    .flagZero(flagZero), .flagNeg(flagNeg), .flagCarry(flagCarry), .flagOvf(flagOvf),
    .isEqual(isEqual), .isLessU(isLessU), .isLessS(isLessS)
  );

  // Reference model from the requirements, using wide integer arithmetic.
  function automatic logic refNeg(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] d;
    d = a - b;
    return d[W-1];
  endfunction

  function automatic logic refOvf(input logic [W-1:0] a, input logic [W-1:0] b);
    int sa, sb, t;
    sa = int'($signed(a));
    sb = int'($signed(b));
    t  = sa - sb;
    return (t > (2 ** (W - 1)) - 1) || (t < -(2 ** (W - 1)));
  endfunction

  task automatic chk(input logic got, input logic exp, input string req, input string what,
                     input logic [W-1:0] a, input logic [W-1:0] b);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s a=%0h b=%0h actual=%0b expected=%0b", req, what, a, b, got, exp);
    end
  endtask

  task automatic applyAndCheck(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    opA = a;
    opB = b;
    #1;   // combinational settle, away from any edge (R9)
    chk(flagZero,  a == b,                    "R1", "flagZero",  a, b);
    chk(flagNeg,   refNeg(a, b),              "R2", "flagNeg",   a, b);
    chk(flagCarry, a >= b,                    "R3", "flagCarry", a, b);
    chk(flagOvf,   refOvf(a, b),              "R4", "flagOvf",   a, b);
    chk(isEqual,   a == b,                    "R5", "isEqual",   a, b);
    chk(isLessU,   a < b,                     "R6", "isLessU",   a, b);
    chk(isLessS,   $signed(a) < $signed(b),   "R7", "isLessS",   a, b);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'h5eed_c0de;
    void'($urandom(seed));

    // Initial operands 0,0: equal, no borrow (R1, R3, R9).
    #1;
    chk(flagZero,  1'b1, "R1", "initial flagZero",  opA, opB);
    chk(flagCarry, 1'b1, "R3", "initial flagCarry", opA, opB);
    chk(isLessS,   1'b0, "R7", "initial isLessS",   opA, opB);

    // Directed corners; R8: 0xFF vs 0x01.
    applyAndCheck(8'hFF, 8'h01);
    chk(isLessU, 1'b0, "R8", "0xFF vs 0x01 unsigned", opA, opB);
    chk(isLessS, 1'b1, "R8", "0xFF vs 0x01 signed",   opA, opB);
    applyAndCheck(8'h80, 8'h7F);   // overflow case, R4
    chk(flagOvf, 1'b1, "R4", "0x80-0x7F overflow", opA, opB);
    applyAndCheck(8'h7F, 8'h80);
    applyAndCheck(8'h00, 8'hFF);
    applyAndCheck(8'h55, 8'h55);

    // Exhaustive sweep (R1..R7).
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        applyAndCheck(W'(i), W'(j));
      end
    end

    // Random pairs, including a bias toward equal operands.
    for (int k = 0; k < 2000; k++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom);
      rb = (k % 8 == 0) ? ra : W'($urandom);
      applyAndCheck(ra, rb);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule